// File: doc/BRIEF.md
# Symmetric Bit-Serial Distributed-Arithmetic FIR Filter

This block filters a stream of 16-bit two's-complement samples with a fixed, even-symmetric 68-tap impulse response, and it uses no multiplier. Each accepted sample enters a 68-deep history. Mirrored history entries are added pairwise into 34 folded operands of 17 bits. The block then walks those operands one bit slice at a time, least significant slice first. Each slice addresses a set of small constant tables, one per group of folded operands. The groups hold 6, 6, 6, 6, 6 and 4 operands, and every entry of a table is the sum of the coefficients whose address bit is set. The summed table outputs go into a right-shifting accumulator. The slice that carries the sign bit is subtracted instead of added.

A parameter sets how many bits are handled per cycle. With one bit per cycle, a result takes 17 cycles: 16 data bits plus one for the carry out of the pre-adders. With two bits per cycle, every table is instantiated twice and a result takes 9 cycles. Upstream logic offers a sample with a valid strobe whenever the busy flag is low. The result appears with a one-cycle valid pulse and stays on the output until the next result replaces it.

Top module: `da_fir`

## Requirements
- R1: While reset is held and after it is released, `busy`, `out_valid` and `out_data` are all zero, and all 68 history entries are zero.
- R2: A cycle with `in_valid` high and `busy` low accepts `in_sample`. `busy` is high from the following cycle for exactly D cycles, where D = ceil(17 / RB): 17 for RB=1 and 9 for RB=2.
- R3: `out_valid` is high for exactly one cycle per accepted sample, in the cycle where `busy` has just fallen. This is D+1 falling clock edges after the acceptance edge, counted from the first falling edge after it.
- R4: `in_valid` is ignored while `busy` is high. Such a sample never enters the history, and later results are unaffected by it.
- R5: Entry 0 of the history is the newest accepted sample. The result is y = sum over t=0..67 of h[t]·x[n−t], computed exactly as a signed value and presented two's-complement in 31 bits.
- R6: The response is symmetric: h[t] = c(t) for t<34 and h[t] = c(67−t) otherwise, with c(k) = ((37·k + 11) mod 61) − 30.
- R7: The result is bit-exact for extreme inputs, including a full history of −32768 and a full history of +32767.
- R8: For equal input sequences, the two-bits-per-cycle variant (RB=2) produces results identical to RB=1.
- R9: Between result pulses, `out_data` keeps the last result.
- R10: A sample offered in the cycle `out_valid` is high is accepted at once, so results can follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_sample | input | 16 | Two's-complement input sample |
| busy | output | 1 | A result is being computed; offers are ignored |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 31 | Two's-complement filter output, held until the next result |

## Verification
The in-RTL properties check the handshake on every cycle. They cover the start of busy after an acceptance, the one-cycle width of the valid pulse, the pulse coinciding with the fall of busy, the bound on the slice counter, the frozen history while busy, and the held output between pulses. Numerical correctness is left to the bench scenarios. These are symmetric folding, grouped table lookups, subtraction of the sign slice, and equal results for both radix settings. The bench checks each result against an independent multiply-accumulate model, which covers random, saturated and most-negative histories and samples injected while busy.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // Controller mode of the serial engine
    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } da_mode_e;

    // Coefficient of folded pair k (fixed response of this filter)
    function automatic int tap_coef(input int k);
        return ((37 * k + 11) % 61) - 30;
    endfunction

    // Table entry: sum of the coefficients of a group whose address bit is set
    function automatic int lut_entry(input int base, input int size, input int addr);
        int s;
        s = 0;
        for (int m = 0; m < size; m++) begin
            if (((addr >> m) & 1) != 0) s += tap_coef(base + m);
        end
        return s;
    endfunction

endpackage

// File: rtl/da_lut.sv
module da_lut #(
    parameter int BASE = 0,
    parameter int SIZE = 6,
    parameter int TW   = 11
) (
    input  logic [SIZE-1:0]        addr,
    output logic signed [TW-1:0]   val
);
    localparam int DEPTH = 1 << SIZE;

    logic signed [TW-1:0] rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        assign rom[a] = TW'(da_fir_pkg::lut_entry(BASE, SIZE, a));
    end

    assign val = rom[addr];
endmodule

// File: rtl/da_fold.sv
module da_fold #(
    parameter int W     = 16,
    parameter int NPAIR = 34,
    parameter int EW    = 17
) (
    input  logic [2*NPAIR-1:0][W-1:0] line,
    output logic [NPAIR-1:0][EW-1:0]  pre
);
    localparam int NTAP = 2 * NPAIR;

    // Mirrored taps share a coefficient: add them, sign-extended to EW bits
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign pre[k] = EW'(signed'(line[k])) + EW'(signed'(line[NTAP-1-k]));
    end
endmodule

// File: rtl/da_digit.sv
module da_digit #(
    parameter int NPAIR = 34,
    parameter int GSIZE = 6,
    parameter int EW    = 17,
    parameter int RB    = 1,
    parameter int TW    = 11,
    parameter int SW    = 14,
    parameter int CNTW  = 5
) (
    input  logic [NPAIR-1:0][EW-1:0]   pre,
    input  logic [CNTW-1:0]            dig,
    input  logic                       last,
    output logic signed [SW+RB-1:0]    dsum
);
    localparam int NGRP = (NPAIR + GSIZE - 1) / GSIZE;
    localparam int DW   = SW + RB;
    localparam int IW   = $clog2(EW);

    logic signed [SW-1:0] bsum [RB];

    // One copy of every table per bit handled in a cycle
    for (genvar b = 0; b < RB; b++) begin : g_bit
        logic [IW-1:0]         bidx;
        logic [NPAIR-1:0]      slice;
        logic signed [TW-1:0]  gval [NGRP];
        logic signed [SW-1:0]  tot;

        assign bidx = IW'(int'(dig) * RB + b);

        for (genvar k = 0; k < NPAIR; k++) begin : g_sl
            assign slice[k] = pre[k][bidx];
        end

        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int GS = (g < NGRP - 1) ? GSIZE : NPAIR - (NGRP - 1) * GSIZE;
            da_lut #(.BASE(g * GSIZE), .SIZE(GS), .TW(TW)) u_lut (
                .addr (slice[g*GSIZE +: GS]),
                .val  (gval[g])
            );
        end

        always_comb begin
            tot = '0;
            for (int g = 0; g < NGRP; g++) tot = tot + SW'(gval[g]);
        end

        assign bsum[b] = tot;
    end

    // Weight bits within the digit; the sign bit (top bit of last digit) subtracts
    always_comb begin
        dsum = '0;
        for (int b = 0; b < RB; b++) begin
            if (last && (b == RB - 1)) dsum = dsum - (DW'(bsum[b]) <<< b);
            else                       dsum = dsum + (DW'(bsum[b]) <<< b);
        end
    end
endmodule

// File: rtl/da_fir.sv
module da_fir #(
    parameter int W     = 16,
    parameter int CW    = 8,
    parameter int NPAIR = 34,
    parameter int GSIZE = 6,
    parameter int RB    = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [W-1:0]                           in_sample,
    output logic                                   busy,
    output logic                                   out_valid,
    output logic [CW+W+1+$clog2(NPAIR+1)-1:0]      out_data
);
    import da_fir_pkg::*;

    localparam int NTAP = 2 * NPAIR;
    localparam int PW   = W + 1;
    localparam int D    = (PW + RB - 1) / RB;
    localparam int EW   = D * RB;
    localparam int TW   = CW + $clog2(GSIZE + 1);
    localparam int SW   = CW + $clog2(NPAIR + 1);
    localparam int DW   = SW + RB;
    localparam int AW   = DW + EW;
    localparam int OW   = CW + PW + $clog2(NPAIR + 1);
    localparam int CNTW = $clog2(D);

    typedef struct packed {
        logic [NTAP-1:0][W-1:0] line;
        da_mode_e               mode;
        logic [CNTW-1:0]        cnt;
        logic [AW-1:0]          acc;
        logic                   vld;
        logic [OW-1:0]          res;
    } state_t;

    state_t st_d, st_q;

    logic [NPAIR-1:0][EW-1:0] pre;
    logic signed [DW-1:0]     dsum;
    logic                     last;

    assign last = (st_q.cnt == CNTW'(D - 1));

    da_fold #(.W(W), .NPAIR(NPAIR), .EW(EW)) u_fold (
        .line (st_q.line),
        .pre  (pre)
    );

    da_digit #(
        .NPAIR(NPAIR), .GSIZE(GSIZE), .EW(EW), .RB(RB),
        .TW(TW), .SW(SW), .CNTW(CNTW)
    ) u_digit (
        .pre  (pre),
        .dig  (st_q.cnt),
        .last (last),
        .dsum (dsum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (st_q.mode)
            MODE_IDLE: begin
                if (in_valid) begin
                    st_d.line = {st_q.line[NTAP-2:0], in_sample};
                    st_d.mode = MODE_RUN;
                    st_d.cnt  = '0;
                    st_d.acc  = '0;
                end
            end
            default: begin
                st_d.acc = ($signed(st_q.acc) >>> RB) + (AW'(dsum) <<< (EW - RB));
                if (last) begin
                    st_d.mode = MODE_IDLE;
                    st_d.vld  = 1'b1;
                    st_d.res  = st_d.acc[OW-1:0];
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = (st_q.mode == MODE_RUN);
    assign out_valid = st_q.vld;
    assign out_data  = st_q.res;

    // R2: an accepted offer starts the computation
    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);

    // R2: slice counter never passes the last digit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt < CNTW'(D)));

    // R3: result strobe lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: busy ends exactly when the result appears
    a_r3_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid);

    // R4: history is frozen while computing
    a_r4_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.line));

    // R9: output holds between result strobes
    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/da_fir_tb.sv
`timescale 1ns/1ps
module da_fir_tb;
    localparam int W     = 16;
    localparam int NPAIR = 34;
    localparam int NTAP  = 68;
    localparam int OW    = 31;
    localparam int NSTIM = 20;

    localparam logic [15:0] STIM [NSTIM] = '{
        16'h0001, 16'h0000, 16'hFFFF, 16'h1234, 16'h8000,
        16'h7FFF, 16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA,
        16'h0F0F, 16'hF0F0, 16'h3C3C, 16'hC3C3, 16'h0002,
        16'hFFFE, 16'h4000, 16'hC000, 16'h6789, 16'h9876
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic busy1, busy2, vld1, vld2;
    logic [OW-1:0] out1, out2;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int hist [NTAP];
    longint last_exp = 0;

    always #2 clk = ~clk;

    da_fir #(.RB(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .busy(busy1), .out_valid(vld1), .out_data(out1)
    );

    da_fir #(.RB(2)) u_dut_r4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .busy(busy2), .out_valid(vld2), .out_data(out2)
    );

    function automatic int cfun(input int k);
        return ((37 * k + 11) % 61) - 30;
    endfunction

    // R6: symmetric response
    function automatic int hcoef(input int t);
        return (t < NPAIR) ? cfun(t) : cfun(NTAP - 1 - t);
    endfunction

    function automatic longint model();
        longint s;
        s = 0;
        for (int t = 0; t < NTAP; t++) s += longint'(hcoef(t)) * longint'(hist[t]);
        return s;
    endfunction

    function automatic longint sx(input logic [OW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Offer x at the current negedge; returns at the negedge where the RB=1 result shows
    task automatic send(input logic [15:0] x, input bit inject, input string req);
        int c1, c2, p1, p2;
        logic [OW-1:0] y1, y2;
        longint e;
        c1 = 0; c2 = 0; p1 = 0; p2 = 0; y1 = '0; y2 = '0;
        in_valid = 1'b1;
        in_sample = x;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sample = '0;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            if (c == 1) begin
                check(busy1 && busy2, "R2/R10 busy after accept", longint'({busy1, busy2}), 3);
            end
            if (inject && c == 2) begin
                in_valid = 1'b1;
                in_sample = 16'h5A5A;
            end
            if (inject && c == 3) begin
                in_valid = 1'b0;
                in_sample = '0;
                check(busy1 && busy2, "R4 busy while injected", longint'({busy1, busy2}), 3);
            end
            if (vld2) begin p2++; c2 = c; y2 = out2; end
            if (vld1) begin p1++; c1 = c; y1 = out1; break; end
        end
        for (int t = NTAP - 1; t > 0; t--) hist[t] = hist[t-1];
        hist[0] = int'($signed(x));
        e = model();
        last_exp = e;
        check(c1 == 18, "R2/R3 latency RB=1", c1, 18);
        check(c2 == 10, "R2/R3 latency RB=2", c2, 10);
        check(p1 == 1 && p2 == 1, "R3 one pulse each", longint'(p1 * 10 + p2), 11);
        check(!busy1, "R3 busy low at result", longint'(busy1), 0);
        check(sx(y1) == e, req, sx(y1), e);
        check(sx(y2) == e, "R8 radix-2 result", sx(y2), e);
    endtask

    initial begin
        for (int t = 0; t < NTAP; t++) hist[t] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy1 && !vld1 && out1 == '0, "R1 reset RB=1", longint'(out1), 0);
        check(!busy2 && !vld2 && out2 == '0, "R1 reset RB=2", longint'(out2), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy1 && !vld1 && out1 == '0, "R1 after release", longint'(out1), 0);

        // R5: table of stimulus samples, expected values from the MAC model
        for (int i = 0; i < NSTIM; i++) send(STIM[i], 1'b0, "R5 table result");

        // R9: result held while idle
        repeat (6) @(negedge clk);
        check(!vld1 && !busy1, "R9 idle", longint'({vld1, busy1}), 0);
        check(sx(out1) == last_exp, "R9 held result", sx(out1), last_exp);
        check(sx(out2) == last_exp, "R9 held result RB=2", sx(out2), last_exp);

        // R7: most negative history
        for (int i = 0; i < NTAP; i++) send(16'h8000, 1'b0, "R7 most negative");
        // R7: most positive history
        for (int i = 0; i < NTAP; i++) send(16'h7FFF, 1'b0, "R7 most positive");
        // R5/R10: alternating extremes back to back
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 16'h8000 : 16'h7FFF, 1'b0, "R10 back to back");

        // R4: offers while busy are dropped
        send(16'h0100, 1'b1, "R4 inject ignored");
        send(16'h0000, 1'b0, "R4 history unchanged");
        send(16'hFEDC, 1'b1, "R4 inject ignored 2");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule